// File: doc/BRIEF.md
# Lockable Flash Configuration Register File

This block is the software-visible configuration store for a flash memory subsystem. It keeps the read wait-state settings, the charge-pump and bank trim words, a flash access-block bit, a configuration word and a bank-mapping control word. Every stored field also drives an output port, so the flash controller and the address mapper read their settings straight from the ports.

Software reaches the block over a simple 32-bit register bus. A write takes effect at the clock edge where `we` is high. Read data is a combinational function of `addr`. Write permission is not uniform. A global configuration lock can only ever be cleared, and once it is clear the protected registers stop accepting writes. The access-block bit and the swap-lock bit can only ever be set. The swap bit is frozen while the swap lock is set.

The swap bit only changes the bank mapping while split mode is on. The block therefore also drives an effective-swap output for the downstream address mapper. In every rule below, a write permission is decided by the value a bit held before the write arrives.

Top module: `flash_cfg_regs`

## Requirements
- R1: The configuration lock (config word bit 0) is 1 after reset. A config write with bit 0 at 0 clears it. Once clear, no write sets it again; only reset restores it.
- R2: While the lock is 0, writes to these registers are ignored and their contents and outputs stay unchanged: both wait-state registers, the pump trim, all bank trim words, the access-block register and the config word.
- R3: Each wait-state register (word 1 for single-cycle mode, word 2 for two-cycle mode) holds 4 bits in bits 3:0 and resets to 0xF. Bits 31:4 read as 0.
- R4: The access-block bit (word 8, bit 0) resets to 0. Writing 1 while the lock is 1 sets it. Writing 0 never clears it; only reset does. The `flash_blocked` output follows this bit.
- R5: The swap-lock bit (word 10, bit 31) resets to 0 and, once written to 1, stays 1 until reset. While it is 1, writes leave the swap bit (word 10, bit 0) unchanged. A write that sets swap-lock still updates swap, because the old swap-lock value is 0.
- R6: `swap_eff` is 1 exactly when the swap bit and split mode are both 1. With split mode 0 it is 0 whatever the swap bit holds.
- R7: The config word (word 9) resets to 0x309. Its fields are: region size in bits 10:8 (32 KB units, reset 3), split mode in bit 4, ROM read-protect disable in bit 3 (reset 1), test mode in bit 2, trim-valid in bit 1 and lock in bit 0. All other bits read as 0.
- R8: Each bank's trim is a high word and a low word: bank 0 uses words 4 and 5, bank 1 uses words 6 and 7. The high word holds 28 bits; bits 31:28 read as 0 and ignore writes. The low word holds 32 bits. `bank_trim[b]` is {high, low} and resets to 0. The pump trim (word 3) holds 32 bits and resets to 0x131A0000.
- R9: `addr` is a word index. Word 0 reads the ID_WORD parameter, and writes to word 0 are ignored. Any word index above 10 reads as 0, and writes to such indices change nothing.
- R10: The bank control word (word 10) is not affected by the configuration lock. The swap bit is writable while the lock is 0, as long as swap-lock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| addr | input | ADDR_W | Word index of the register access |
| we | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ws_single | output | 4 | Wait states for single-cycle flash reads |
| ws_double | output | 4 | Wait states for two-cycle flash reads |
| pump_trim | output | 32 | Charge-pump trim word |
| bank_trim | output | 2 x 60 | Per-bank trim, {high 28 bits, low 32 bits} |
| flash_blocked | output | 1 | User read, program and erase are blocked |
| region_size | output | 3 | Secure region size in 32 KB blocks |
| split_mode | output | 1 | Address space is split into two bank regions |
| rom_rdprot_dis | output | 1 | ROM read protection disabled |
| test_mode | output | 1 | Flash test mode enabled |
| trim_valid | output | 1 | Trim words have been marked valid |
| cfg_lock | output | 1 | Configuration lock; 1 means protected writes are allowed |
| swap_lock | output | 1 | Swap bit frozen |
| swap | output | 1 | Stored bank-swap request |
| swap_eff | output | 1 | Bank swap in effect (swap and split mode) |

## Verification
The assertions watch the one-way bits on every cycle: a cleared lock stays clear, a set access block or swap lock stays set, and the swap bit holds still under swap lock. They also check that nothing protected moves while the lock is clear, and that the reserved top bits of a high trim word read as zero. The reset values, the field packing of each word and the same-write behaviour (a write that clears the lock or sets swap-lock still updates its other fields) can only be shown by the bench's scenarios. The same holds for reads of unmapped and identification words and for the effective-swap output across split-mode changes.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;
  localparam int WORD_W    = 32;
  localparam int WS_W      = 4;
  localparam int TRIM_HI_W = 28;
  localparam int TRIM_LO_W = 32;
  localparam int TRIM_W    = TRIM_HI_W + TRIM_LO_W;
  localparam int NUM_BANKS = 2;
  localparam int REGION_W  = 3;
  localparam int MAP_W     = 8;

  // word indices
  localparam logic [MAP_W-1:0] A_ID    = 8'd0;
  localparam logic [MAP_W-1:0] A_WS1   = 8'd1;
  localparam logic [MAP_W-1:0] A_WS2   = 8'd2;
  localparam logic [MAP_W-1:0] A_PUMP  = 8'd3;
  localparam logic [MAP_W-1:0] A_TRIM  = 8'd4;  // bank b: high at 4+2b, low at 5+2b
  localparam logic [MAP_W-1:0] A_BLOCK = 8'd8;
  localparam logic [MAP_W-1:0] A_CFG   = 8'd9;
  localparam logic [MAP_W-1:0] A_BANK  = 8'd10;

  localparam logic [WORD_W-1:0] PUMP_RST = 32'h131A_0000;

  // config word bit positions
  localparam int CFG_LOCK   = 0;
  localparam int CFG_TRIMV  = 1;
  localparam int CFG_TEST   = 2;
  localparam int CFG_ROMDIS = 3;
  localparam int CFG_SPLIT  = 4;
  localparam int CFG_REGION = 8;

  // bank control word bit positions
  localparam int BK_SWAP  = 0;
  localparam int BK_SLOCK = 31;
endpackage

// File: rtl/flash_cfg_field.sv
module flash_cfg_field #(
  parameter int           W   = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (en) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nx;
  end
endmodule

// File: rtl/flash_cfg_rdmux.sv
module flash_cfg_rdmux
  import flash_cfg_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter logic [WORD_W-1:0] ID_WORD = 32'hA51C_0100
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [WS_W-1:0]                    ws_single,
  input  logic [WS_W-1:0]                    ws_double,
  input  logic [WORD_W-1:0]                  pump_trim,
  input  logic [NUM_BANKS-1:0][TRIM_W-1:0]   bank_trim,
  input  logic                               flash_blocked,
  input  logic [WORD_W-1:0]                  cfg_word,
  input  logic [WORD_W-1:0]                  bank_word,
  output logic [WORD_W-1:0]                  rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_ID))    rdata = ID_WORD;
    if (addr == ADDR_W'(A_WS1))   rdata = WORD_W'(ws_single);
    if (addr == ADDR_W'(A_WS2))   rdata = WORD_W'(ws_double);
    if (addr == ADDR_W'(A_PUMP))  rdata = pump_trim;
    if (addr == ADDR_W'(A_BLOCK)) rdata = WORD_W'(flash_blocked);
    if (addr == ADDR_W'(A_CFG))   rdata = cfg_word;
    if (addr == ADDR_W'(A_BANK))  rdata = bank_word;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(A_TRIM + MAP_W'(2 * b)))
        rdata = WORD_W'(bank_trim[b][TRIM_W-1:TRIM_LO_W]);
      if (addr == ADDR_W'(A_TRIM + MAP_W'(2 * b + 1)))
        rdata = bank_trim[b][TRIM_LO_W-1:0];
    end
  end
endmodule

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
  import flash_cfg_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [WORD_W-1:0] ID_WORD = 32'hA51C_0100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             we,
  input  logic [WORD_W-1:0]                wdata,
  output logic [WORD_W-1:0]                rdata,
  output logic [WS_W-1:0]                  ws_single,
  output logic [WS_W-1:0]                  ws_double,
  output logic [WORD_W-1:0]                pump_trim,
  output logic [NUM_BANKS-1:0][TRIM_W-1:0] bank_trim,
  output logic                             flash_blocked,
  output logic [REGION_W-1:0]              region_size,
  output logic                             split_mode,
  output logic                             rom_rdprot_dis,
  output logic                             test_mode,
  output logic                             trim_valid,
  output logic                             cfg_lock,
  output logic                             swap_lock,
  output logic                             swap,
  output logic                             swap_eff
);
  // write strobes; protected ones are gated by the lock value before the write
  logic wr_ws1, wr_ws2, wr_pump, wr_block, wr_cfg, wr_bank;
  logic [WORD_W-1:0] cfg_word, bank_word;

  assign wr_ws1   = we && (addr == ADDR_W'(A_WS1))   && cfg_lock;
  assign wr_ws2   = we && (addr == ADDR_W'(A_WS2))   && cfg_lock;
  assign wr_pump  = we && (addr == ADDR_W'(A_PUMP))  && cfg_lock;
  assign wr_block = we && (addr == ADDR_W'(A_BLOCK)) && cfg_lock;
  assign wr_cfg   = we && (addr == ADDR_W'(A_CFG))   && cfg_lock;
  assign wr_bank  = we && (addr == ADDR_W'(A_BANK));

  flash_cfg_field #(.W(WS_W), .RST({WS_W{1'b1}})) u_ws1 (
    .clk(clk), .rst_n(rst_n), .en(wr_ws1), .d(wdata[WS_W-1:0]), .q(ws_single));
  flash_cfg_field #(.W(WS_W), .RST({WS_W{1'b1}})) u_ws2 (
    .clk(clk), .rst_n(rst_n), .en(wr_ws2), .d(wdata[WS_W-1:0]), .q(ws_double));
  flash_cfg_field #(.W(WORD_W), .RST(PUMP_RST)) u_pump (
    .clk(clk), .rst_n(rst_n), .en(wr_pump), .d(wdata), .q(pump_trim));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [MAP_W-1:0] HI_A = A_TRIM + MAP_W'(2 * b);
    localparam logic [MAP_W-1:0] LO_A = A_TRIM + MAP_W'(2 * b + 1);
    logic wr_hi, wr_lo;
    assign wr_hi = we && (addr == ADDR_W'(HI_A)) && cfg_lock;
    assign wr_lo = we && (addr == ADDR_W'(LO_A)) && cfg_lock;
    flash_cfg_field #(.W(TRIM_HI_W), .RST('0)) u_hi (
      .clk(clk), .rst_n(rst_n), .en(wr_hi), .d(wdata[TRIM_HI_W-1:0]),
      .q(bank_trim[b][TRIM_W-1:TRIM_LO_W]));
    flash_cfg_field #(.W(TRIM_LO_W), .RST('0)) u_lo (
      .clk(clk), .rst_n(rst_n), .en(wr_lo), .d(wdata[TRIM_LO_W-1:0]),
      .q(bank_trim[b][TRIM_LO_W-1:0]));
  end

  flash_cfg_field #(.W(REGION_W), .RST(3'd3)) u_region (
    .clk(clk), .rst_n(rst_n), .en(wr_cfg),
    .d(wdata[CFG_REGION+REGION_W-1:CFG_REGION]), .q(region_size));
  flash_cfg_field #(.W(4), .RST(4'b0100)) u_modes (
    .clk(clk), .rst_n(rst_n), .en(wr_cfg),
    .d({wdata[CFG_SPLIT], wdata[CFG_ROMDIS], wdata[CFG_TEST], wdata[CFG_TRIMV]}),
    .q({split_mode, rom_rdprot_dis, test_mode, trim_valid}));

  // one-way bits
  logic lock_nx, block_nx, slock_nx, swap_nx;

  always_comb begin
    lock_nx  = cfg_lock;
    block_nx = flash_blocked;
    slock_nx = swap_lock;
    swap_nx  = swap;
    if (wr_cfg && !wdata[CFG_LOCK]) lock_nx  = 1'b0;
    if (wr_block && wdata[0])       block_nx = 1'b1;
    if (wr_bank && wdata[BK_SLOCK]) slock_nx = 1'b1;
    if (wr_bank && !swap_lock)      swap_nx  = wdata[BK_SWAP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lock      <= 1'b1;
      flash_blocked <= 1'b0;
      swap_lock     <= 1'b0;
      swap          <= 1'b0;
    end else begin
      cfg_lock      <= lock_nx;
      flash_blocked <= block_nx;
      swap_lock     <= slock_nx;
      swap          <= swap_nx;
    end
  end

  assign swap_eff = swap & split_mode;

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_REGION+REGION_W-1:CFG_REGION] = region_size;
    cfg_word[CFG_SPLIT]  = split_mode;
    cfg_word[CFG_ROMDIS] = rom_rdprot_dis;
    cfg_word[CFG_TEST]   = test_mode;
    cfg_word[CFG_TRIMV]  = trim_valid;
    cfg_word[CFG_LOCK]   = cfg_lock;
    bank_word = '0;
    bank_word[BK_SLOCK] = swap_lock;
    bank_word[BK_SWAP]  = swap;
  end

  flash_cfg_rdmux #(.ADDR_W(ADDR_W), .ID_WORD(ID_WORD)) u_rdmux (
    .addr(addr), .ws_single(ws_single), .ws_double(ws_double),
    .pump_trim(pump_trim), .bank_trim(bank_trim), .flash_blocked(flash_blocked),
    .cfg_word(cfg_word), .bank_word(bank_word), .rdata(rdata));

  // checks
  assert_lock_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_lock |=> !cfg_lock);

  assert_locked_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_lock |=> ($stable(ws_single) && $stable(ws_double) && $stable(pump_trim)
                   && $stable(bank_trim) && $stable(region_size) && $stable(split_mode)
                   && $stable(rom_rdprot_dis) && $stable(test_mode)
                   && $stable(trim_valid) && $stable(flash_blocked)));

  assert_block_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_blocked |=> flash_blocked);

  assert_swaplock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_lock |=> swap_lock);

  assert_swap_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_lock |=> $stable(swap));

  assert_trim_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_TRIM)) |-> (rdata[WORD_W-1:TRIM_HI_W] == '0));
endmodule

// File: tb/tb_flash_cfg_regs.sv
module tb_flash_cfg_regs;
  localparam int CLK_P = 10;
  localparam logic [31:0] IDW = 32'hA51C_0100;

  logic clk, rst_n, we;
  logic [7:0] addr;
  logic [31:0] wdata, rdata;
  logic [3:0] ws_single, ws_double;
  logic [31:0] pump_trim;
  logic [1:0][59:0] bank_trim;
  logic flash_blocked, split_mode, rom_rdprot_dis, test_mode, trim_valid;
  logic cfg_lock, swap_lock, swap, swap_eff;
  logic [2:0] region_size;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  flash_cfg_regs #(.ADDR_W(8), .ID_WORD(IDW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .ws_single(ws_single), .ws_double(ws_double), .pump_trim(pump_trim),
    .bank_trim(bank_trim), .flash_blocked(flash_blocked), .region_size(region_size),
    .split_mode(split_mode), .rom_rdprot_dis(rom_rdprot_dis), .test_mode(test_mode),
    .trim_valid(trim_valid), .cfg_lock(cfg_lock), .swap_lock(swap_lock),
    .swap(swap), .swap_eff(swap_eff));

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'd0, v);  chk("R9 id word", v, IDW);
    rd(8'd1, v);  chk("R3 ws1 reset", v, 32'hF);
    chk("R3 ws_double reset", ws_double, 4'hF);
    rd(8'd3, v);  chk("R8 pump reset", v, 32'h131A_0000);
    rd(8'd9, v);  chk("R7 cfg reset", v, 32'h309);
    chk("R1 lock reset", cfg_lock, 1'b1);
    chk("R4 block reset", flash_blocked, 1'b0);
    rd(8'd10, v); chk("R5 bank word reset", v, 32'h0);
    chk("R8 trim reset", bank_trim[1], 60'h0);
  endtask

  task automatic t_waitstate();
    logic [31:0] v;
    wr(8'd1, 32'hFFFF_FFF5);
    rd(8'd1, v); chk("R3 ws1 upper bits zero", v, 32'h5);
    chk("R3 ws_single port", ws_single, 4'h5);
    wr(8'd2, 32'h3);
    rd(8'd2, v); chk("R3 ws2 readback", v, 32'h3);
  endtask

  task automatic t_trims();
    logic [31:0] v;
    wr(8'd4, 32'hFFFF_FFFF);
    rd(8'd4, v); chk("R8 b0 high reserved zero", v, 32'h0FFF_FFFF);
    wr(8'd5, 32'h1234_5678);
    chk("R8 bank0 trim port", bank_trim[0], 60'hFFF_FFFF_1234_5678);
    wr(8'd6, 32'hA5A5_A5A5);
    rd(8'd6, v); chk("R8 b1 high masked", v, 32'h05A5_A5A5);
    wr(8'd3, 32'hDEAD_BEEF);
    rd(8'd3, v); chk("R8 pump write", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_config();
    logic [31:0] v;
    wr(8'd9, 32'hFFFF_FFFF);
    rd(8'd9, v); chk("R7 cfg all ones", v, 32'h71F);
    chk("R7 region port", region_size, 3'd7);
    chk("R7 test port", test_mode, 1'b1);
    wr(8'd9, 32'h311);
    rd(8'd9, v); chk("R7 cfg pattern", v, 32'h311);
    chk("R7 trim_valid port", trim_valid, 1'b0);
    chk("R7 rom prot port", rom_rdprot_dis, 1'b0);
  endtask

  task automatic t_swap();
    wr(8'd10, 32'h1);
    chk("R6 swap with split", swap_eff, 1'b1);
    wr(8'd9, 32'h301);
    chk("R6 swap no split", swap_eff, 1'b0);
    chk("R6 swap bit kept", swap, 1'b1);
    wr(8'd9, 32'h311);
    chk("R6 split back", swap_eff, 1'b1);
    wr(8'd10, 32'h0);
    chk("R6 swap cleared", swap_eff, 1'b0);
  endtask

  task automatic t_block();
    logic [31:0] v;
    wr(8'd8, 32'h1);
    chk("R4 block set", flash_blocked, 1'b1);
    wr(8'd8, 32'h0);
    rd(8'd8, v); chk("R4 block sticky", v, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'd11, v);  chk("R9 unmapped 11", v, 32'h0);
    rd(8'd255, v); chk("R9 unmapped 255", v, 32'h0);
    wr(8'd0, 32'h0);
    rd(8'd0, v);   chk("R9 id not writable", v, IDW);
    wr(8'd32, 32'hFFFF_FFFF);
    rd(8'd32, v);  chk("R9 unmapped write", v, 32'h0);
    rd(8'd1, v);   chk("R9 unmapped write no alias", v, 32'h5);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(8'd9, 32'h310);
    rd(8'd9, v); chk("R1 lock cleared", v, 32'h310);
    wr(8'd1, 32'hA);
    rd(8'd1, v); chk("R2 ws1 frozen", v, 32'h5);
    wr(8'd2, 32'hC);
    chk("R2 ws2 frozen", ws_double, 4'h3);
    wr(8'd3, 32'h0);
    rd(8'd3, v); chk("R2 pump frozen", v, 32'hDEAD_BEEF);
    wr(8'd5, 32'h0);
    chk("R2 trim frozen", bank_trim[0], 60'hFFF_FFFF_1234_5678);
    wr(8'd9, 32'hFFFF_FFFF);
    rd(8'd9, v); chk("R1 lock stays clear", v, 32'h310);
    chk("R2 test mode frozen", test_mode, 1'b0);
    wr(8'd10, 32'h1);
    chk("R10 swap writable while locked", swap, 1'b1);
  endtask

  task automatic t_swaplock();
    logic [31:0] v;
    wr(8'd10, 32'h8000_0000);
    rd(8'd10, v); chk("R5 same-write swap update", v, 32'h8000_0000);
    wr(8'd10, 32'h1);
    chk("R5 swap frozen", swap, 1'b0);
    wr(8'd10, 32'h0);
    chk("R5 swap lock sticky", swap_lock, 1'b1);
  endtask

  task automatic t_rereset();
    do_reset();
    chk("R1 lock back after reset", cfg_lock, 1'b1);
    chk("R4 block clear after reset", flash_blocked, 1'b0);
    chk("R5 swap lock clear after reset", swap_lock, 1'b0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_waitstate();
    t_trims();
    t_config();
    t_swap();
    t_block();
    t_unmapped();
    t_lock();
    t_swaplock();
    t_rereset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule